// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Incremental Squash

This block holds in-flight instructions for several hardware threads in a single buffer of `DEPTH` entries. Each thread sees its own queue in program order. An allocation carries a thread number and a sequence tag and lands at that thread's youngest end. A completion carries a thread number and a tag, and it marks the matching entry as finished. A retire request removes the thread's oldest entry, but only when that entry is finished or has been squashed. The block reports, per thread, the oldest and youngest tags, the occupancy, the free space and a run state. It also reports the total count, full, empty and whether any thread could commit.

How entries are shared among threads is set by a policy input. Under dynamic sharing any thread may take the whole buffer. Under partitioned sharing each active thread gets an equal slice. Under threshold sharing each thread is capped at a fixed percentage of the buffer.

A squash request names a thread and a tag, and it kills every entry of that thread younger than the tag. The kill is done by a walker that starts at the thread's youngest entry and moves toward the oldest, marking at most `SQ_WIDTH` entries per clock. Marked entries stay in place until they are retired, so the youngest tag does not change.

The allocation port is valid/ready and has these rules:
- A transfer happens on a clock edge where both valid and ready are high.
- Ready depends only on the addressed thread: it is low while that thread squashes, or is being told to squash in the same cycle.
- Ready does not reflect free space. The producer must check `thr_free_o` or `total_o` before it raises valid.

Top module: `mt_rob`

## Requirements
- R1: After reset, every count is zero, `empty_o`=1, `full_o`=0, all done flags are 1, `can_commit_o`=0, and no head is ready.
- R2: An accepted allocation appends to its thread's queue. The thread's count rises by one, `tail_seq_o` shows the new tag, and `head_seq_o` keeps showing the oldest tag not yet retired.
- R3: `total_o` equals the sum of the thread counts. `full_o`=1 exactly when `total_o`=`DEPTH`. `empty_o`=1 exactly when `total_o`=0. `thr_empty_o[t]`=1 exactly when thread t's count is 0.
- R4: The per-thread limit follows `policy_i`:
  - 0 (dynamic): `DEPTH`.
  - 1 (partitioned): `DEPTH` divided by the number of set bits in `active_i`, or `DEPTH` if no bit is set.
  - 2 (threshold): `DEPTH*THRESH_PCT/100`, with a minimum of 1.
  - 3: treated as 0.
- R5: `thr_free_o[t]` is the smaller of (limit minus thread count, floored at 0) and (`DEPTH` minus `total_o`). It follows policy, mask and count changes in the same cycle.
- R6: A completion sets the finished flag of the live entry of that thread whose tag matches. `head_ready_o[t]` is 1 when thread t is non-empty and its head is finished or squashed. `can_commit_o` is 1 when some thread that is active and not squashing has a ready head.
- R7: A retire removes the head of `retire_tid_i` only when that head is ready and the thread is not squashing. Otherwise it has no effect.
- R8: An allocation and a retire in the same cycle update the per-thread counts and the total consistently. The total is left unchanged.
- R9: A squash marks every entry of the thread whose tag is younger than the squash tag. Younger means that (entry tag minus squash tag), taken as a signed `SEQ_W`-bit value, is positive. Older and equal entries keep their state. Marked entries stay allocated, and `tail_seq_o` is unchanged.
- R10: The walk lasts max(1, ceil(n/`SQ_WIDTH`)) cycles after the request edge when all n entries are younger. When at least one entry is not younger, it lasts floor(k/`SQ_WIDTH`)+1 cycles for k younger entries. A new request to a thread already squashing restarts the walk.
- R11: `sq_done_o[t]`=0 from the request edge until the walk ends. `all_sq_done_o`=1 only when no thread squashes. `thr_state_o[t]` encodes 2 for squashing, 1 for active and not squashing, and 0 for inactive.
- R12: `alloc_ready_o`=0 when the addressed thread is squashing or receives a squash request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | Sharing policy: 0 dynamic, 1 partitioned, 2 threshold |
| active_i | input | N_THR | Active-thread mask |
| alloc_valid_i | input | 1 | Allocation valid |
| alloc_ready_o | output | 1 | Allocation ready (addressed thread not squashing) |
| alloc_tid_i | input | TW | Allocation thread |
| alloc_seq_i | input | SEQ_W | Allocation tag |
| cmpl_valid_i | input | 1 | Completion strobe |
| cmpl_tid_i | input | TW | Completion thread |
| cmpl_seq_i | input | SEQ_W | Completion tag |
| retire_i | input | 1 | Retire request |
| retire_tid_i | input | TW | Retire thread |
| squash_i | input | 1 | Squash request |
| squash_tid_i | input | TW | Squash thread |
| squash_seq_i | input | SEQ_W | Squash tag; younger entries are killed |
| head_seq_o | output | N_THR*SEQ_W | Oldest tag per thread |
| head_ready_o | output | N_THR | Head finished or squashed, per thread |
| head_squashed_o | output | N_THR | Head marked squashed, per thread |
| tail_seq_o | output | N_THR*SEQ_W | Youngest tag per thread |
| thr_count_o | output | N_THR*CW | Entries held per thread |
| thr_free_o | output | N_THR*CW | Entries still allowed per thread |
| thr_empty_o | output | N_THR | Thread holds nothing |
| thr_state_o | output | N_THR*2 | Run state per thread |
| total_o | output | CW | Entries held overall |
| full_o | output | 1 | Buffer full |
| empty_o | output | 1 | Buffer empty |
| sq_done_o | output | N_THR | Thread not squashing |
| all_sq_done_o | output | 1 | No thread squashing |
| can_commit_o | output | 1 | Some active thread has a ready head |

## Verification
The checker watches four things on every cycle:
- the total count against the sum of the thread counts and against `DEPTH`;
- that no allocation is accepted for a squashing thread;
- that a squash request drops the thread's done flag on the next edge, and that the youngest tag holds still while a walk runs;
- that a retire on a head that is not ready leaves the thread's count unchanged.

Only the bench's scenarios can show the following:
- the walk's cycle counts, including a walk that ends at an older entry and one that crosses the tag wrap;
- which entries end up marked;
- the limit arithmetic for each policy.

// File: rtl/mt_rob_pkg.sv
package mt_rob_pkg;
  typedef enum logic [1:0] {
    POL_DYNAMIC   = 2'd0,
    POL_PARTITION = 2'd1,
    POL_THRESHOLD = 2'd2
  } share_pol_e;

  typedef enum logic [1:0] {
    TS_IDLE   = 2'd0,
    TS_RUN    = 2'd1,
    TS_SQUASH = 2'd2
  } thr_state_e;
endpackage

// File: rtl/mt_rob_limits.sv
module mt_rob_limits #(
  parameter int N_THR      = 2,
  parameter int DEPTH      = 8,
  parameter int THRESH_PCT = 75,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       policy_i,
  input  logic [N_THR-1:0] active_i,
  output logic [CW-1:0]    limit_o
);
  import mt_rob_pkg::*;

  localparam int THR_RAW = (DEPTH * THRESH_PCT) / 100;
  localparam int THR_LIM = (THR_RAW < 1) ? 1 : ((THR_RAW > DEPTH) ? DEPTH : THR_RAW);

  int n_act;
  logic [CW-1:0] part_lim;

  always_comb begin
    n_act    = $countones(active_i);
    part_lim = CW'(DEPTH);
    for (int d = 1; d <= N_THR; d++) begin
      if (n_act == d) part_lim = CW'(DEPTH / d);
    end
  end

  always_comb begin
    case (share_pol_e'(policy_i))
      POL_PARTITION: limit_o = part_lim;
      POL_THRESHOLD: limit_o = CW'(THR_LIM);
      default:       limit_o = CW'(DEPTH);
    endcase
  end
endmodule

// File: rtl/mt_rob_thread_q.sv
module mt_rob_thread_q #(
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 6,
  parameter int SQ_WIDTH = 2,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [SEQ_W-1:0] push_seq_i,
  input  logic             pop_i,
  input  logic             cmpl_i,
  input  logic [SEQ_W-1:0] cmpl_seq_i,
  input  logic             sq_req_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  output logic             push_fire_o,
  output logic             pop_fire_o,
  output logic             blocked_o,
  output logic             squashing_o,
  output logic [CW-1:0]    count_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic             head_rdy_o,
  output logic             head_sq_o,
  output logic [SEQ_W-1:0] tail_seq_o
);
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [DEPTH-1:0] live_q, done_q, sqd_q;
  logic [AW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q, walk_q;
  logic             sq_act_q;
  logic [SEQ_W-1:0] sq_seq_q;

  logic [DEPTH-1:0] mark;
  logic             halt, walk_fin;
  logic [AW-1:0]    pos;

  function automatic logic younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    return (diff != '0) && !diff[SEQ_W-1];
  endfunction

  assign blocked_o   = sq_act_q | sq_req_i;
  assign squashing_o = sq_act_q;
  assign count_o     = cnt_q;
  assign head_seq_o  = seq_q[head_q];
  assign tail_seq_o  = seq_q[tail_q - AW'(1)];
  assign head_sq_o   = (cnt_q != '0) && sqd_q[head_q];
  assign head_rdy_o  = (cnt_q != '0) && (done_q[head_q] || sqd_q[head_q]);
  assign push_fire_o = push_i && !blocked_o;
  assign pop_fire_o  = pop_i && head_rdy_o && !blocked_o;

  // walker: inspect up to SQ_WIDTH slots, youngest first
  always_comb begin
    mark = '0;
    halt = 1'b0;
    pos  = '0;
    for (int k = 0; k < SQ_WIDTH; k++) begin
      pos = head_q + AW'(walk_q) - AW'(1) - AW'(k);
      if (!halt) begin
        if (k < int'(walk_q) && younger(seq_q[pos], sq_seq_q)) mark[pos] = 1'b1;
        else halt = 1'b1;
      end
    end
    walk_fin = halt || (int'(walk_q) <= SQ_WIDTH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) seq_q[i] <= '0;
      live_q   <= '0;
      done_q   <= '0;
      sqd_q    <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      walk_q   <= '0;
      sq_act_q <= 1'b0;
      sq_seq_q <= '0;
    end else begin
      if (cmpl_i) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (live_q[i] && seq_q[i] == cmpl_seq_i) done_q[i] <= 1'b1;
        end
      end
      if (sq_req_i) begin
        sq_act_q <= 1'b1;
        sq_seq_q <= sq_seq_i;
        walk_q   <= cnt_q;
      end else if (sq_act_q) begin
        sqd_q  <= sqd_q | mark;
        walk_q <= (int'(walk_q) > SQ_WIDTH) ? walk_q - CW'(SQ_WIDTH) : '0;
        if (walk_fin) sq_act_q <= 1'b0;
      end
      if (push_fire_o) begin
        seq_q[tail_q]  <= push_seq_i;
        live_q[tail_q] <= 1'b1;
        done_q[tail_q] <= 1'b0;
        sqd_q[tail_q]  <= 1'b0;
        tail_q         <= tail_q + AW'(1);
      end
      if (pop_fire_o) begin
        live_q[head_q] <= 1'b0;
        head_q         <= head_q + AW'(1);
      end
      cnt_q <= cnt_q + CW'(push_fire_o) - CW'(pop_fire_o);
    end
  end
endmodule

// File: rtl/mt_rob.sv
module mt_rob #(
  parameter int N_THR      = 2,
  parameter int DEPTH      = 8,
  parameter int SEQ_W      = 6,
  parameter int SQ_WIDTH   = 2,
  parameter int THRESH_PCT = 75,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int TW        = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             policy_i,
  input  logic [N_THR-1:0]       active_i,
  input  logic                   alloc_valid_i,
  output logic                   alloc_ready_o,
  input  logic [TW-1:0]          alloc_tid_i,
  input  logic [SEQ_W-1:0]       alloc_seq_i,
  input  logic                   cmpl_valid_i,
  input  logic [TW-1:0]          cmpl_tid_i,
  input  logic [SEQ_W-1:0]       cmpl_seq_i,
  input  logic                   retire_i,
  input  logic [TW-1:0]          retire_tid_i,
  input  logic                   squash_i,
  input  logic [TW-1:0]          squash_tid_i,
  input  logic [SEQ_W-1:0]       squash_seq_i,
  output logic [N_THR*SEQ_W-1:0] head_seq_o,
  output logic [N_THR-1:0]       head_ready_o,
  output logic [N_THR-1:0]       head_squashed_o,
  output logic [N_THR*SEQ_W-1:0] tail_seq_o,
  output logic [N_THR*CW-1:0]    thr_count_o,
  output logic [N_THR*CW-1:0]    thr_free_o,
  output logic [N_THR-1:0]       thr_empty_o,
  output logic [N_THR*2-1:0]     thr_state_o,
  output logic [CW-1:0]          total_o,
  output logic                   full_o,
  output logic                   empty_o,
  output logic [N_THR-1:0]       sq_done_o,
  output logic                   all_sq_done_o,
  output logic                   can_commit_o
);
  import mt_rob_pkg::*;

  logic [CW-1:0]    limit;
  logic [N_THR-1:0] push_fire, pop_fire, blocked, squashing;
  logic [CW-1:0]    total_q;
  logic [CW-1:0]    space_left;

  mt_rob_limits #(.N_THR(N_THR), .DEPTH(DEPTH), .THRESH_PCT(THRESH_PCT)) u_limits (
    .policy_i (policy_i),
    .active_i (active_i),
    .limit_o  (limit)
  );

  assign space_left = CW'(DEPTH) - total_q;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic [CW-1:0] cnt, by_limit;

    mt_rob_thread_q #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_WIDTH(SQ_WIDTH)) u_q (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (alloc_valid_i && alloc_tid_i == TW'(t)),
      .push_seq_i  (alloc_seq_i),
      .pop_i       (retire_i && retire_tid_i == TW'(t)),
      .cmpl_i      (cmpl_valid_i && cmpl_tid_i == TW'(t)),
      .cmpl_seq_i  (cmpl_seq_i),
      .sq_req_i    (squash_i && squash_tid_i == TW'(t)),
      .sq_seq_i    (squash_seq_i),
      .push_fire_o (push_fire[t]),
      .pop_fire_o  (pop_fire[t]),
      .blocked_o   (blocked[t]),
      .squashing_o (squashing[t]),
      .count_o     (cnt),
      .head_seq_o  (head_seq_o[t*SEQ_W +: SEQ_W]),
      .head_rdy_o  (head_ready_o[t]),
      .head_sq_o   (head_squashed_o[t]),
      .tail_seq_o  (tail_seq_o[t*SEQ_W +: SEQ_W])
    );

    assign by_limit = (limit > cnt) ? limit - cnt : '0;
    assign thr_free_o[t*CW +: CW]  = (by_limit < space_left) ? by_limit : space_left;
    assign thr_count_o[t*CW +: CW] = cnt;
    assign thr_empty_o[t]          = (cnt == '0);
    assign sq_done_o[t]            = !squashing[t];
    assign thr_state_o[t*2 +: 2]   = squashing[t] ? TS_SQUASH : (active_i[t] ? TS_RUN : TS_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) total_q <= '0;
    else        total_q <= total_q + CW'($countones(push_fire)) - CW'($countones(pop_fire));
  end

  assign alloc_ready_o = !blocked[alloc_tid_i];
  assign total_o       = total_q;
  assign full_o        = (total_q == CW'(DEPTH));
  assign empty_o       = (total_q == '0);
  assign all_sq_done_o = (squashing == '0);
  assign can_commit_o  = |(head_ready_o & active_i & ~squashing);
endmodule

// File: rtl/mt_rob_chk.sv
module mt_rob_chk #(
  parameter int N_THR    = 2,
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 6,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int TW      = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   alloc_valid_i,
  input logic                   alloc_ready_o,
  input logic [TW-1:0]          alloc_tid_i,
  input logic                   retire_i,
  input logic [TW-1:0]          retire_tid_i,
  input logic                   squash_i,
  input logic [TW-1:0]          squash_tid_i,
  input logic [N_THR-1:0]       head_ready_o,
  input logic [N_THR*SEQ_W-1:0] tail_seq_o,
  input logic [N_THR*CW-1:0]    thr_count_o,
  input logic [CW-1:0]          total_o,
  input logic [N_THR-1:0]       sq_done_o
);
  int unsigned cnt_sum;
  always_comb begin
    cnt_sum = 0;
    for (int t = 0; t < N_THR; t++) cnt_sum += int'(thr_count_o[t*CW +: CW]);
  end

  // R3
  total_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(total_o) == cnt_sum);

  // R3
  total_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(total_o) <= DEPTH);

  for (genvar t = 0; t < N_THR; t++) begin : g_t
    // R12
    alloc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid_i && alloc_tid_i == TW'(t) && !sq_done_o[t]) |-> !alloc_ready_o);

    // R11
    sq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_i && squash_tid_i == TW'(t)) |=> !sq_done_o[t]);

    // R9
    tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sq_done_o[t] && $past(!sq_done_o[t])) |-> $stable(tail_seq_o[t*SEQ_W +: SEQ_W]));

    // R7
    retire_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && retire_tid_i == TW'(t) && !head_ready_o[t] &&
       !(alloc_valid_i && alloc_tid_i == TW'(t)))
      |=> $stable(thr_count_o[t*CW +: CW]));
  end
endmodule

bind mt_rob mt_rob_chk #(.N_THR(N_THR), .DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_valid_i (alloc_valid_i),
  .alloc_ready_o (alloc_ready_o),
  .alloc_tid_i   (alloc_tid_i),
  .retire_i      (retire_i),
  .retire_tid_i  (retire_tid_i),
  .squash_i      (squash_i),
  .squash_tid_i  (squash_tid_i),
  .head_ready_o  (head_ready_o),
  .tail_seq_o    (tail_seq_o),
  .thr_count_o   (thr_count_o),
  .total_o       (total_o),
  .sq_done_o     (sq_done_o)
);

// File: tb/mt_rob_test.sv
module mt_rob_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_THR = 2, DEPTH = 8, SEQ_W = 6, SQW = 2, PCT = 75;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = 1;

  logic clk = 0, rst_n = 0;
  logic [1:0] policy_i = 0;
  logic [N_THR-1:0] active_i = '1;
  logic alloc_valid_i = 0, cmpl_valid_i = 0, retire_i = 0, squash_i = 0;
  logic [TW-1:0] alloc_tid_i = 0, cmpl_tid_i = 0, retire_tid_i = 0, squash_tid_i = 0;
  logic [SEQ_W-1:0] alloc_seq_i = 0, cmpl_seq_i = 0, squash_seq_i = 0;
  logic alloc_ready_o, full_o, empty_o, all_sq_done_o, can_commit_o;
  logic [N_THR*SEQ_W-1:0] head_seq_o, tail_seq_o;
  logic [N_THR-1:0] head_ready_o, head_squashed_o, thr_empty_o, sq_done_o;
  logic [N_THR*CW-1:0] thr_count_o, thr_free_o;
  logic [N_THR*2-1:0] thr_state_o;
  logic [CW-1:0] total_o;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mt_rob #(.N_THR(N_THR), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_WIDTH(SQW), .THRESH_PCT(PCT)) uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    alloc_valid_i = 0; cmpl_valid_i = 0; retire_i = 0; squash_i = 0;
  endtask

  task automatic alloc(input int tid, input int seq);
    alloc_valid_i = 1; alloc_tid_i = TW'(tid); alloc_seq_i = SEQ_W'(seq); step();
  endtask
  task automatic cmpl(input int tid, input int seq);
    cmpl_valid_i = 1; cmpl_tid_i = TW'(tid); cmpl_seq_i = SEQ_W'(seq); step();
  endtask
  task automatic retire(input int tid);
    retire_i = 1; retire_tid_i = TW'(tid); step();
  endtask

  function automatic int cnt(input int t);  return int'(thr_count_o[t*CW +: CW]); endfunction
  function automatic int free(input int t); return int'(thr_free_o[t*CW +: CW]); endfunction
  function automatic int hd(input int t);   return int'(head_seq_o[t*SEQ_W +: SEQ_W]); endfunction
  function automatic int tl(input int t);   return int'(tail_seq_o[t*SEQ_W +: SEQ_W]); endfunction
  function automatic int st(input int t);   return int'(thr_state_o[t*2 +: 2]); endfunction

  // policy, mask, expected free for thread 0 on an empty buffer (R4)
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{0, 3, 8}, '{1, 3, 4}, '{1, 1, 8}, '{2, 3, 6}, '{1, 0, 8}, '{3, 3, 8}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R1 reset state
    check("R1 total", int'(total_o), 0);
    check("R1 empty", int'(empty_o), 1);
    check("R1 full", int'(full_o), 0);
    check("R1 sq_done", int'(sq_done_o), 3);
    check("R1 can_commit", int'(can_commit_o), 0);
    check("R11 state run", st(0), 1);

    for (int i = 0; i < NV; i++) begin
      policy_i = 2'(VEC[i][0]); active_i = N_THR'(VEC[i][1]); #1;
      check($sformatf("R4 limit vec%0d", i), free(0), VEC[i][2]);
    end
    active_i = 2'b01; #1;
    check("R11 state idle", st(1), 0);
    policy_i = 0; active_i = '1; #1;

    // R2 allocation order
    for (int s = 10; s <= 14; s++) alloc(0, s);
    alloc(1, 40); alloc(1, 41);
    check("R2 cnt0", cnt(0), 5);
    check("R2 head0", hd(0), 10);
    check("R2 tail0", tl(0), 14);
    check("R2 head1", hd(1), 40);
    check("R3 total", int'(total_o), 7);
    check("R5 free0 dyn", free(0), 1);
    policy_i = 1; #1;
    check("R5 free0 part", free(0), 0);
    check("R5 free1 part", free(1), 1);
    policy_i = 0; #1;

    // R6/R7 completion and retire
    cmpl(0, 11);
    check("R6 head not ready", int'(head_ready_o[0]), 0);
    check("R6 no commit", int'(can_commit_o), 0);
    retire(0);
    check("R7 retire ignored", cnt(0), 5);
    cmpl(0, 10);
    check("R6 head ready", int'(head_ready_o[0]), 1);
    check("R6 commit", int'(can_commit_o), 1);
    retire(0);
    check("R7 retired", cnt(0), 4);
    check("R7 head", hd(0), 11);
    retire(0);
    check("R7 head2", hd(0), 12);
    cmpl(0, 12);
    // R8 simultaneous alloc and retire
    alloc_valid_i = 1; alloc_tid_i = 1; alloc_seq_i = 42;
    retire_i = 1; retire_tid_i = 0; step();
    check("R8 cnt0", cnt(0), 2);
    check("R8 cnt1", cnt(1), 3);
    check("R8 total", int'(total_o), 5);
    alloc(1, 43); alloc(1, 44); alloc(1, 45);
    check("R3 full", int'(full_o), 1);
    check("R5 free at full", free(0) + free(1), 0);

    // R9/R10 squash thread 1 after tag 41: four younger, three passes
    squash_i = 1; squash_tid_i = 1; squash_seq_i = 41;
    alloc_tid_i = 1; #1;
    check("R12 ready low on request", int'(alloc_ready_o), 0);
    step();
    check("R11 state squash", st(1), 2);
    check("R11 all done low", int'(all_sq_done_o), 0);
    alloc_tid_i = 1; #1;
    check("R12 ready low", int'(alloc_ready_o), 0);
    cmpl(1, 40);
    retire(1);
    check("R10 still squashing", int'(sq_done_o[1]), 0);
    check("R7 no retire while squashing", cnt(1), 6);
    step();
    check("R10 done after 3", int'(sq_done_o[1]), 1);
    check("R11 all done", int'(all_sq_done_o), 1);
    check("R9 tail kept", tl(1), 45);
    check("R9 cnt kept", cnt(1), 6);
    check("R9 older kept", int'(head_squashed_o[1]), 0);
    retire(1);
    check("R9 41 not squashed", int'(head_ready_o[1]), 0);
    cmpl(1, 41); retire(1);
    check("R9 42 squashed", int'(head_squashed_o[1]), 1);
    check("R6 squashed ready", int'(head_ready_o[1]), 1);
    retire(1);
    check("R9 43 squashed", int'(head_squashed_o[1]), 1);
    check("R3 total", int'(total_o), 5);

    // R10 single-pass squash (nothing younger than 50)
    squash_i = 1; squash_tid_i = 1; squash_seq_i = 50; step();
    check("R10 one-pass start", int'(sq_done_o[1]), 0);
    step();
    check("R10 one-pass end", int'(sq_done_o[1]), 1);

    // R9 wrap-aware ordering on thread 0
    cmpl(0, 13); cmpl(0, 14); retire(0); retire(0);
    check("R3 thr empty", int'(thr_empty_o[0]), 1);
    alloc(0, 62); alloc(0, 63); alloc(0, 0); alloc(0, 1);
    squash_i = 1; squash_tid_i = 0; squash_seq_i = 63; step();
    step();
    check("R10 wrap pass1", int'(sq_done_o[0]), 0);
    step();
    check("R10 wrap done", int'(sq_done_o[0]), 1);
    check("R9 wrap tail", tl(0), 1);
    check("R9 62 live", int'(head_squashed_o[0]), 0);
    cmpl(0, 62); retire(0);
    check("R9 63 live", int'(head_squashed_o[0]), 0);
    cmpl(0, 63); retire(0);
    check("R9 wrapped 0 squashed", int'(head_squashed_o[0]), 1);
    check("R9 head 0", hd(0), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule